// File: doc/BRIEF.md
# Clocked Byte Serial Shifter

This block is a synchronous serial port that moves one byte per transfer. Software writes a byte into the data register. It then writes the mode register to pick a shift clock, a bit order and the pin enables, and to set the run bit. The block shifts the byte out on `sdo` and shifts a byte in from `sdi`, one bit per shift-clock period, for eight periods.

The shift clock comes from one of two places. It can be a divided copy of the system clock, which is taken to be the instruction cycle. It can also be an external clock on `sck_i`, which is synchronised and edge-detected in the system clock domain. Output data changes on the falling shift edge and input data is sampled on the rising edge.

When the eighth rising edge arrives, the run bit drops by itself and a sticky done flag sets. If interrupts are enabled, the done flag raises `irq`. The received byte then reads back from the data register.

Top module: `sio_shifter`

## Requirements
- R1: After reset, the mode register (address 0) reads 0x00, `sck_o` is 1, and `irq`, `sck_oe` and `sdo_oe` are 0.
- R2: The internal shift clock stays at 1 while the run bit (mode bit 0) is 0. When a transfer starts, its first falling edge comes exactly one full half-period after the cycle that writes the run bit.
- R3: Clock select (mode bits 3:2) sets the internal half-period. Value 0 gives 1 cycle, value 1 gives 4 cycles and value 2 gives 16 cycles, so the full periods are 2, 8 and 32 cycles. A transfer ends 16 half-periods after the start write.
- R4: Direction (mode bit 1) picks the bit order: 0 sends bit 0 first and 1 sends bit 7 first. `sdo` changes only on falling shift edges and `sdi` is sampled on rising edges. The data register (address 1) reads back the received byte, placed at the bit positions that match the chosen order.
- R5: Clock select value 3 takes the shift clock from `sck_i` through a synchroniser, and in that case `sck_oe` stays 0.
- R6: After the eighth rising shift edge, the run bit reads 0 and the done flag (mode bit 7) reads 1.
- R7: Writing 0 to mode bit 7 clears the done flag. Writing 1 to it leaves the flag unchanged, and the other mode bits still take the written values.
- R8: `irq` is 1 exactly when both the interrupt enable (mode bit 6) and the done flag are 1.
- R9: A write to the data register while a transfer runs is ignored and does not change the received byte.
- R10: Writing 0 to the run bit during a transfer aborts it. The run bit reads 0 on the next cycle, the done flag stays 0, and `sck_o` returns to 1.
- R11: `sdo_oe` follows mode bit 4. `sck_oe` follows mode bit 5 while an internal clock is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one instruction cycle per period) |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mode, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internal shift clock |
| sck_oe | output | 1 | Drive enable for the shift clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the serial data pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that ends the write cycle, and the combinational read shows the new value in the very next cycle. With an internal clock of half-period H, fall k lands 2k-1 half-periods after that edge and rise k lands 2k half-periods after it, so the run bit clears and the done flag sets exactly 16·H cycles after the start write. The bench counts cycles from the start write and checks every falling edge against these positions. It samples `sdo` in the cycle right after each falling edge and checks the run and done bits at cycles 16·H-1 and 16·H. With the external clock, each `sck_i` edge reaches the engine three cycles later, so the bench holds each phase for six cycles and samples at the end of the phase.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    CK_FAST = 2'b00,
    CK_MID  = 2'b01,
    CK_SLOW = 2'b10,
    CK_EXT  = 2'b11
  } cksel_e;

  typedef struct packed {
    logic   done_flag;
    logic   irq_en;
    logic   sck_out_en;
    logic   sdo_out_en;
    cksel_e cksel;
    logic   msb_first;
    logic   busy;
  } mode_t;

  // half-period in system cycles for an internal clock selection
  function automatic int half_period(cksel_e s, int f, int m, int sl);
    case (s)
      CK_FAST: return f;
      CK_MID:  return m;
      CK_SLOW: return sl;
      default: return 1;
    endcase
  endfunction

  // one shift step: the new bit enters at the end opposite the output end
  function automatic logic [7:0] shift_in(logic [7:0] cur, logic b, logic msb);
    return msb ? {cur[6:0], b} : {b, cur[7:1]};
  endfunction

  function automatic logic out_bit(logic [7:0] cur, logic msb);
    return msb ? cur[7] : cur[0];
  endfunction

endpackage

// File: rtl/sio_mode_reg.sv
module sio_mode_reg
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic [7:0] wdata,
  input  logic       done,
  output mode_t      mode_q,
  output logic       start_req
);

  mode_t w;
  logic  stop_req;

  always_comb begin
    w         = mode_t'(wdata);
    start_req = wr_mode && w.busy && !mode_q.busy;
    stop_req  = wr_mode && !w.busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      if (wr_mode) begin
        mode_q.irq_en     <= w.irq_en;
        mode_q.sck_out_en <= w.sck_out_en;
        mode_q.sdo_out_en <= w.sdo_out_en;
        mode_q.cksel      <= w.cksel;
        mode_q.msb_first  <= w.msb_first;
      end
      if (done)                              mode_q.done_flag <= 1'b1;
      else if (wr_mode && !w.done_flag)      mode_q.done_flag <= 1'b0;
      if (stop_req)                          mode_q.busy <= 1'b0;
      else if (start_req)                    mode_q.busy <= 1'b1;
      else if (done)                         mode_q.busy <= 1'b0;
    end
  end

  // R7: the flag only falls through an explicit write of 0
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.done_flag && !(wr_mode && !wdata[7]) |=> mode_q.done_flag);

  // R6: end of transfer sets the flag and drops the run bit
  a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_mode |=> mode_q.done_flag && !mode_q.busy);

  // R10: writing run=0 stops at once
  a_r10_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && !wdata[0] |=> !mode_q.busy);

endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int DIV_FAST = 1,
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  cksel_e cksel,
  input  logic   sck_i,
  output logic   sck_int,
  output logic   rise_ev,
  output logic   fall_ev
);

  localparam int CNT_W = $clog2(DIV_SLOW + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hp_m1;
  logic             sck_q;
  logic [2:0]       sync_q;
  logic             is_ext, int_tick, ext_rise, ext_fall;

  always_comb begin
    is_ext   = (cksel == CK_EXT);
    hp_m1    = CNT_W'(half_period(cksel, DIV_FAST, DIV_MID, DIV_SLOW) - 1);
    int_tick = run && !is_ext && (cnt >= hp_m1);
    ext_rise = sync_q[1] && !sync_q[2];
    ext_fall = !sync_q[1] && sync_q[2];
    rise_ev  = is_ext ? (run && ext_rise) : (int_tick && !sck_q);
    fall_ev  = is_ext ? (run && ext_fall) : (int_tick && sck_q);
    sck_int  = sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], sck_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (!run || is_ext) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (int_tick) begin
      cnt   <= '0;
      sck_q <= !sck_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R2: clock rests high whenever not running
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sck_q);

  // R3: never both edges in one cycle
  a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev));

endmodule

// File: rtl/sio_engine.sv
module sio_engine
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       start_req,
  input  logic       rise_ev,
  input  logic       fall_ev,
  input  logic       msb_first,
  input  logic       sdi,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  output logic [7:0] sh_q,
  output logic       sdo,
  output logic       done
);

  logic [2:0] bitcnt;
  logic       rx_q;
  logic       last_rise;

  always_comb begin
    last_rise = rise_ev && (bitcnt == 3'd7);
    done      = run && last_rise;
    sdo       = out_bit(sh_q, msb_first);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bitcnt <= '0;
      rx_q   <= 1'b0;
    end else if (!run) begin
      if (start_req) bitcnt <= '0;
      if (wr_data)   sh_q   <= wdata;
    end else if (rise_ev) begin
      if (last_rise) begin
        sh_q <= shift_in(sh_q, sdi, msb_first);
      end else begin
        rx_q   <= sdi;
        bitcnt <= bitcnt + 3'd1;
      end
    end else if (fall_ev && bitcnt != 3'd0) begin
      sh_q <= shift_in(sh_q, rx_q, msb_first);
    end
  end

  // R9: shift register only moves on shift edges while running
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    run && !rise_ev && !fall_ev |=> $stable(sh_q));

  // R4: output moves only at a falling edge or the final rising edge
  a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    run && !fall_ev && !last_rise |=> $stable(sdo));

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
#(
  parameter int DIV_FAST = 1,
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       irq
);

  mode_t      mode_q;
  logic       start_req, done, rise_ev, fall_ev, sck_int;
  logic       wr_mode, wr_data;
  logic [7:0] sh_q;

  assign wr_mode = bus_wr && !bus_addr;
  assign wr_data = bus_wr &&  bus_addr;

  sio_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_mode),
    .wdata     (bus_wdata),
    .done      (done),
    .mode_q    (mode_q),
    .start_req (start_req)
  );

  sio_clkgen #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode_q.busy),
    .cksel   (mode_q.cksel),
    .sck_i   (sck_i),
    .sck_int (sck_int),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  sio_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (mode_q.busy),
    .start_req (start_req),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .msb_first (mode_q.msb_first),
    .sdi       (sdi),
    .wr_data   (wr_data),
    .wdata     (bus_wdata),
    .sh_q      (sh_q),
    .sdo       (sdo),
    .done      (done)
  );

  always_comb begin
    bus_rdata = bus_addr ? sh_q : mode_q;
    sck_o     = sck_int;
    sck_oe    = mode_q.sck_out_en && (mode_q.cksel != CK_EXT);
    sdo_oe    = mode_q.sdo_out_en;
    irq       = mode_q.done_flag && mode_q.irq_en;
  end

  // R8: a request only with the flag set
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> u_mode.mode_q.done_flag);

  // R5: external clock never drives the clock pin
  a_r5_ext_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.cksel == CK_EXT) |-> !sck_oe);

endmodule

// File: tb/sio_shifter_tb_top.sv
module sio_shifter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sck_i = 1'b1, sdi = 1'b0;
  logic       sck_o, sck_oe, sdo, sdo_oe, irq;
  int         checks = 0, failures = 0;
  bit         done_run = 1'b0;

  always #10 clk = ~clk;

  sio_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 1'b0;
  endtask

  function automatic int hp_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : 16;
  endfunction

  // internal-clock transfer; poke writes the data register mid-transfer
  task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rx,
                          input logic [1:0] cks, input logic msb, input bit poke);
    int hp = hp_of(cks);
    int falls = 0, bad_time = 0;
    bit prev = 1'b1;
    logic [7:0] got = '0;
    logic [7:0] d;
    wr_reg(1'b1, tx);
    wr_reg(1'b0, {4'b0011, cks, msb, 1'b1});
    for (int j = 1; j <= 16 * hp; j++) begin
      @(negedge clk);
      if (bus_wr) begin bus_wr = 1'b0; bus_addr = 1'b0; end
      if (prev && !sck_o) begin
        falls++;
        if ((j % (2 * hp)) != hp) bad_time++;
        got[msb ? 8 - falls : falls - 1] = sdo;
        sdi = rx[msb ? 8 - falls : falls - 1];
      end
      prev = sck_o;
      if (j == 16 * hp - 1) begin
        rd_reg(1'b0, d);
        chk(d[0] == 1'b1, "R6 busy before end", d[0], 1);
      end
      if (poke && j == 3) begin
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hFF;
      end
    end
    rd_reg(1'b0, d);
    chk(d[7] && !d[0], "R6 done flag set, run clear", d, {1'b1, 7'b0});
    chk(falls == 8 && bad_time == 0, "R3 falling edge timing", bad_time + falls, 8);
    chk(got == tx, "R4 serial output order", got, tx);
    rd_reg(1'b1, d);
    chk(d == rx, poke ? "R9 received byte kept" : "R4 received byte", d, rx);
  endtask

  task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rx, input logic msb);
    logic [7:0] got = '0;
    logic [7:0] d;
    wr_reg(1'b1, tx);
    wr_reg(1'b0, {4'b0011, 2'b11, msb, 1'b1});
    chk(sck_oe == 1'b0, "R5 clock pin not driven", sck_oe, 0);
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0;
      sdi = rx[msb ? 7 - k : k];
      repeat (6) @(negedge clk);
      got[msb ? 7 - k : k] = sdo;
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
    end
    rd_reg(1'b0, d);
    chk(d[7] && !d[0], "R5 external transfer done", d, {1'b1, 7'b0});
    chk(got == tx, "R5 external output", got, tx);
    rd_reg(1'b1, d);
    chk(d == rx, "R5 external received", d, rx);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(1'b0, d);
    chk(d == 8'h00, "R1 mode reset", d, 0);
    chk(sck_o && !irq && !sck_oe && !sdo_oe, "R1 pins at reset",
        {sck_o, irq, sck_oe, sdo_oe}, 4'b1000);
  endtask

  task automatic t_flag_irq();
    logic [7:0] d;
    // flag is 1 from the previous transfer; write 1 to it with ie=1, clock sel 2
    wr_reg(1'b0, 8'b1100_1000);
    rd_reg(1'b0, d);
    chk(d == 8'b1100_1000, "R7 write 1 keeps flag, others written", d, 8'hC8);
    chk(irq == 1'b1, "R8 irq with ie and flag", irq, 1);
    wr_reg(1'b0, 8'b1000_0000);
    chk(irq == 1'b0, "R8 no irq when ie=0", irq, 0);
    wr_reg(1'b0, 8'b0100_0000);
    rd_reg(1'b0, d);
    chk(d == 8'b0100_0000 && !irq, "R7 write 0 clears flag", d, 8'h40);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    wr_reg(1'b0, 8'b0000_1001);
    repeat (20) @(negedge clk);
    chk(sck_o == 1'b0, "R2 clock running", sck_o, 0);
    wr_reg(1'b0, 8'b0000_1000);
    rd_reg(1'b0, d);
    chk(d[0] == 1'b0 && d[7] == 1'b0, "R10 abort clears run, no flag", d, 8'h08);
    @(negedge clk);
    chk(sck_o == 1'b1, "R10 clock back high", sck_o, 1);
    repeat (40) @(negedge clk);
    chk(sck_o == 1'b1, "R2 idle stays high", sck_o, 1);
  endtask

  task automatic t_pins();
    wr_reg(1'b0, 8'b0001_0000);
    chk(sdo_oe && !sck_oe, "R11 data enable only", {sdo_oe, sck_oe}, 2'b10);
    wr_reg(1'b0, 8'b0010_0100);
    chk(!sdo_oe && sck_oe, "R11 clock enable internal", {sdo_oe, sck_oe}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    xfer_int(8'hA5, 8'h3C, 2'd0, 1'b0, 1'b0);
    xfer_int(8'h96, 8'hC3, 2'd1, 1'b1, 1'b0);
    xfer_int(8'h01, 8'h80, 2'd2, 1'b0, 1'b0);
    t_flag_irq();
    xfer_int(8'h5A, 8'h69, 2'd1, 1'b0, 1'b1);
    xfer_ext(8'hB4, 8'h2D, 1'b1);
    xfer_ext(8'h3E, 8'hD1, 1'b0);
    t_stop();
    t_pins();
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule